// File: doc/BRIEF.md
# Selectable Half-Duty Clock Divider

This block divides a fast clock by a ratio of 3, 4, 5 or 6, chosen by a 2-bit code, and keeps the high time at exactly half the output period for every ratio. Even ratios are built on rising edges only. Odd ratios add a copy of the rising-edge phase that is delayed by half a source cycle on the falling edge, which stretches the high time to N/2 source periods.

A select input picks the clock that feeds the divider. One setting uses the fast source clock. The other uses the slower reference clock, which then goes through the same divide path. The divided clock drives two output lanes. Each lane has its own enable, and the tri-state pad is modelled as a data bit plus an enable bit.

An active-low asynchronous reset forces both outputs low and restarts the count. A new ratio code is picked up only at the boundary of an output period, so changing the code never produces a short pulse.

Top module: `odd_even_clk_div`

## Requirements
- R1: The ratio code maps to the divide ratio N as follows: 0 gives 3, 1 gives 4, 2 gives 5 and 3 gives 6. The output period is N periods of the selected clock.
- R2: The output is high for N/2 periods of the selected clock. For odd N this includes a half period, so the duty cycle is 50% for every ratio.
- R3: While rst_ni is low, both q_o bits are low. This takes effect at once, with no clock edge needed. After release, dividing starts again.
- R4: After rst_ni is released, the first rising edge of the output coincides with the N-th rising edge of the selected clock.
- R5: A code change made during an output period does not affect that period. The new ratio applies from the next rising edge of the output. No high or low pulse is shorter than 1.5 periods of the selected clock.
- R6: q_en_o[k] follows oe_i[k] for each lane k, and the two lanes are independent. An enable of 1 means the lane is driven.
- R7: When bypass_i is 1, the reference clock is divided instead of the source clock, with the same ratio map and the same duty cycle. bypass_i is changed only while the block is held in reset.
- R8: q_o[0] and q_o[1] carry identical waveforms at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Fast source clock |
| ref_clk_i | input | 1 | Reference clock, divided when bypass is selected |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| bypass_i | input | 1 | 1 selects the reference clock as the divider input |
| ratio_code_i | input | 2 | Ratio code; N = 3 + code |
| oe_i | input | 2 | Per-lane output enable |
| q_o | output | 2 | Divided clock, one bit per lane |
| q_en_o | output | 2 | Per-lane pad enable |

## Verification
Each of the four codes is measured directly on both clock sources. The period, the high time and the lane match are read from edge timestamps, so an error in the ratio map can be told apart from a duty error on the odd ratios. Directed cases cover the following:
- the time to the first edge after reset release, which separates a correct start from an off-by-one start;
- a code change just after a rising edge, which shows whether the old period finishes before the new ratio takes over;
- a reset asserted mid-period.

Code changes at random times between measurements, together with random enable patterns, are checked against a monitor of the narrowest high and low pulses seen.

// File: rtl/odd_even_clk_div_pkg.sv
`timescale 1ns/1ps
package odd_even_clk_div_pkg;
  localparam int unsigned CODE_W   = 2;
  localparam int unsigned BASE_DIV = 3;
  localparam int unsigned MAX_DIV  = BASE_DIV + (1 << CODE_W) - 1;
  localparam int unsigned CNT_W    = $clog2(MAX_DIV + 1);
  localparam int unsigned NUM_OUT  = 2;
endpackage

// File: rtl/clk_route.sv
`timescale 1ns/1ps
module clk_route (
  input  logic src_clk_i,
  input  logic ref_clk_i,
  input  logic bypass_i,
  output logic clk_o
);
  always_comb clk_o = bypass_i ? ref_clk_i : src_clk_i;
endmodule

// File: rtl/ratio_divider.sv
`timescale 1ns/1ps
module ratio_divider #(
  parameter int unsigned CODE_W   = 2,
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned BASE_DIV = 3,
  parameter int unsigned MAX_DIV  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              div_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  ratio_o,
  output logic              rise_o
);
  localparam logic [CNT_W-1:0] BaseVal = CNT_W'(BASE_DIV);
  localparam logic [CNT_W-1:0] MaxVal  = CNT_W'(MAX_DIV);

  logic [CNT_W-1:0] cnt_q, div_q, code_div, eff_div, nxt_cnt, nxt_div, half;
  logic             run_q, rise_q, odd_q, fall_q, wrap, rise_d;

  always_comb begin
    code_div = BaseVal + CNT_W'(code_i);
    // before the first wrap the live code sets the start-up length
    eff_div  = run_q ? div_q : code_div;
    wrap     = (cnt_q >= eff_div - CNT_W'(1));
    nxt_cnt  = wrap ? '0 : cnt_q + CNT_W'(1);
    nxt_div  = wrap ? code_div : eff_div;
    half     = nxt_div >> 1;
    rise_d   = (run_q | wrap) & (nxt_cnt < half);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      div_q  <= MaxVal;
      run_q  <= 1'b0;
      rise_q <= 1'b0;
      odd_q  <= 1'b0;
    end else begin
      cnt_q  <= nxt_cnt;
      if (wrap) div_q <= code_div;
      run_q  <= run_q | wrap;
      rise_q <= rise_d;
      odd_q  <= nxt_div[0];
    end
  end

  // half-cycle shifted copy stretches odd high time by 0.5 period
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= 1'b0;
    else         fall_q <= rise_q;
  end

  always_comb begin
    div_o   = rise_q | (odd_q & fall_q);
    cnt_o   = cnt_q;
    ratio_o = div_q;
    rise_o  = rise_q;
  end
endmodule

// File: rtl/out_lanes.sv
`timescale 1ns/1ps
module out_lanes #(
  parameter int unsigned NUM_OUT = 2
) (
  input  logic               div_i,
  input  logic [NUM_OUT-1:0] oe_i,
  output logic [NUM_OUT-1:0] q_o,
  output logic [NUM_OUT-1:0] q_en_o
);
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
    always_comb begin
      q_o[k]    = div_i;
      q_en_o[k] = oe_i[k];
    end
  end
endmodule

// File: rtl/odd_even_clk_div.sv
`timescale 1ns/1ps
module odd_even_clk_div
  import odd_even_clk_div_pkg::*;
(
  input  logic               src_clk_i,
  input  logic               ref_clk_i,
  input  logic               rst_ni,
  input  logic               bypass_i,
  input  logic [CODE_W-1:0]  ratio_code_i,
  input  logic [NUM_OUT-1:0] oe_i,
  output logic [NUM_OUT-1:0] q_o,
  output logic [NUM_OUT-1:0] q_en_o
);
  logic             div_clk, div_out, rise_w;
  logic [CNT_W-1:0] cnt_w, ratio_w;

  clk_route u_route (
    .src_clk_i (src_clk_i),
    .ref_clk_i (ref_clk_i),
    .bypass_i  (bypass_i),
    .clk_o     (div_clk)
  );

  ratio_divider #(
    .CODE_W  (CODE_W),
    .CNT_W   (CNT_W),
    .BASE_DIV(BASE_DIV),
    .MAX_DIV (MAX_DIV)
  ) u_div (
    .clk_i  (div_clk),
    .rst_ni (rst_ni),
    .code_i (ratio_code_i),
    .div_o  (div_out),
    .cnt_o  (cnt_w),
    .ratio_o(ratio_w),
    .rise_o (rise_w)
  );

  out_lanes #(.NUM_OUT(NUM_OUT)) u_lanes (
    .div_i (div_out),
    .oe_i  (oe_i),
    .q_o   (q_o),
    .q_en_o(q_en_o)
  );
endmodule

// File: rtl/odd_even_clk_div_chk.sv
`timescale 1ns/1ps
module odd_even_clk_div_chk
  import odd_even_clk_div_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [CNT_W-1:0]   cnt_i,
  input logic [CNT_W-1:0]   ratio_i,
  input logic               rise_i,
  input logic [NUM_OUT-1:0] q_i
);
  assert_reset_low_R3: assert property (@(posedge clk_i) !rst_ni |-> (q_i == '0));

  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i < ratio_i);

  assert_rise_at_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rise_i) |-> (cnt_i == '0));

  assert_ratio_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_i) |-> (cnt_i == '0));
endmodule

bind odd_even_clk_div odd_even_clk_div_chk u_chk (
  .clk_i  (div_clk),
  .rst_ni (rst_ni),
  .cnt_i  (cnt_w),
  .ratio_i(ratio_w),
  .rise_i (rise_w),
  .q_i    (q_o)
);

// File: tb/tb_odd_even_clk_div.sv
`timescale 1ns/1ps
module tb_odd_even_clk_div;
  localparam real SRC_P = 8.0;
  localparam real REF_P = 26.0;

  logic       src_clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0, bypass = 1'b0;
  logic [1:0] code = 2'd0, oe = 2'b11;
  logic [1:0] q, q_en;

  int  n_chk = 0, n_err = 0;
  bit  done = 1'b0;
  bit  mon = 1'b0;
  real last_t = 0.0, min_w = 1.0e9, w;

  always #(SRC_P/2) src_clk = ~src_clk;
  always #(REF_P/2) ref_clk = ~ref_clk;

  odd_even_clk_div dut (
    .src_clk_i(src_clk), .ref_clk_i(ref_clk), .rst_ni(rst_n),
    .bypass_i(bypass), .ratio_code_i(code), .oe_i(oe),
    .q_o(q), .q_en_o(q_en)
  );

  function automatic int exp_ratio(input logic [1:0] c);
    return 3 + int'(c);
  endfunction

  task automatic chk_r(input string req, input real act, input real exp);
    n_chk++;
    if ((act - exp) > 0.01 || (exp - act) > 0.01) begin
      n_err++;
      $display("FAIL %s: actual=%0.2f expected=%0.2f", req, act, exp);
    end
  endtask

  task automatic chk_b(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  always @(q[0]) begin
    if (mon) begin
      w = $realtime - last_t;
      if (w < min_w) min_w = w;
    end
    last_t = $realtime;
  end

  // R1 R2 R8: period, high time and lane match
  task automatic measure(input real per);
    real t1, t2, t3;
    int  n;
    n = exp_ratio(code);
    @(posedge q[0]); @(posedge q[0]);
    t1 = $realtime;
    #1 chk_b("R8 lanes high", q, 2'b11);
    @(negedge q[0]); t2 = $realtime;
    #1 chk_b("R8 lanes low", q, 2'b00);
    @(posedge q[0]); t3 = $realtime;
    chk_r("R1 period", t3 - t1, n * per);
    chk_r("R2 high time", t2 - t1, n * per / 2.0);
  endtask

  // R4: first edge at N-th selected-clock rising edge
  task automatic restart(input logic byp, input logic [1:0] c);
    real t0, per;
    rst_n = 1'b0;
    #20;
    bypass = byp;
    code = c;
    per = byp ? REF_P : SRC_P;
    #40;
    if (byp) @(negedge ref_clk); else @(negedge src_clk);
    rst_n = 1'b1;
    t0 = $realtime;
    @(posedge q[0]);
    chk_r("R4 first rise", $realtime - t0, per / 2.0 + (exp_ratio(c) - 1) * per);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    real tp, t1, t2;
    void'($urandom(32'd2024));
    #3;
    chk_b("R3 reset low", q, 2'b00);
    chk_b("R6 enables at reset", q_en, 2'b11);

    // R1 R2 on source clock, every code
    for (int c = 0; c < 4; c++) begin
      restart(1'b0, 2'(c));
      measure(SRC_P);
    end

    // R7 bypass path, every code
    for (int c = 0; c < 4; c++) begin
      restart(1'b1, 2'(c));
      measure(REF_P);
    end

    // R5 directed: change right after a rising edge
    restart(1'b0, 2'd3);
    @(posedge q[0]); tp = $realtime;
    #1 code = 2'd0;
    @(posedge q[0]); t1 = $realtime;
    chk_r("R5 old period kept", t1 - tp, 6 * SRC_P);
    @(posedge q[0]); t2 = $realtime;
    chk_r("R5 new period used", t2 - t1, 3 * SRC_P);

    // R3 mid-period reset
    @(posedge q[0]);
    #3 rst_n = 1'b0;
    #1 chk_b("R3 async low", q, 2'b00);
    #50 chk_b("R3 held low", q, 2'b00);
    rst_n = 1'b1;
    measure(SRC_P);

    // random code changes with pulse-width monitor, random enables
    @(posedge q[0]);
    min_w = 1.0e9;
    mon = 1'b1;
    for (int i = 0; i < 12; i++) begin
      #($urandom_range(60, 1));
      code = 2'($urandom_range(3, 0));
      oe = 2'($urandom_range(3, 0));
      #1 chk_b("R6 enable follow", q_en, oe);
      measure(SRC_P);
    end
    mon = 1'b0;
    chk_r("R5 no runt", (min_w >= 1.5 * SRC_P) ? 1.0 : min_w, 1.0);

    // R6 independence, data keeps toggling with lanes disabled
    oe = 2'b01;
    #1 chk_b("R6 lane0 only", q_en, 2'b01);
    oe = 2'b00;
    #1 chk_b("R6 both off", q_en, 2'b00);
    measure(SRC_P);
    oe = 2'b10;
    #1 chk_b("R6 lane1 only", q_en, 2'b10);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule